// File: doc/BRIEF.md
# Data Access Permission Checker

This block judges a single data access in one clock cycle, using a translation entry that an external lookup has already found. It takes the virtual address, the access width, the load/store flag, the current privilege mode, and the entry fields: hit flag, page frame number, per-mode read and write enable masks, and the fault-on-read and fault-on-write bits. One cycle later it returns either a physical address or a fault code, together with a four-bit memory-management status word that an exception handler can record.

Before any entry is consulted, two address-only checks run. The first is a natural-alignment test. The second detects a kernel direct-mapped window, selected by a fixed value in the top address bits, which bypasses translation. When neither applies, the entry's hit flag and its permission fields decide the outcome. Three wrapping counters record no-fault loads, no-fault stores and permission violations. The block holds no translation storage.

Top module: `dxlate_perm_chk`

## Requirements
- R1: Each cycle with `req_vld` high gives exactly one cycle with `rsp_vld` high on the next cycle, and no other cycle has `rsp_vld` high. Reset clears `rsp_vld` and all three counters.
- R2: A size code s means 2^s bytes (0 = 1, 1 = 2, 2 = 4, 3 = 8). If `req_vaddr & (2^s - 1)` is nonzero, the result is fault code 1 (alignment). The status word then holds only bit 0 (write), which is set for stores.
- R3: An address whose bits [47:41] equal 0x7E lies in the direct-mapped window. In mode 0 (kernel) such an access has no fault, and its physical address is `req_vaddr[43:0]`. All translation-entry inputs are ignored for it.
- R4: For a window access that passes, if bit 40 of the physical address is set, bits 43:40 of the physical address are forced to one.
- R5: A window access in any mode other than 0 gives fault code 2 (access violation). The status word has bit 1 (access violation) set, and bit 0 set for stores.
- R6: Outside the window, when `tlb_hit` is low, the result is fault code 4 (miss). The status word holds only bit 0, which is set for stores.
- R7: The permission bit used is bit `req_mode` of the read or write enable mask. The mode codes are 0 = kernel, 1 = executive, 2 = supervisor and 3 = user.
- R8: A store whose write-enable bit is clear gives fault code 3 (page fault). The status word has bits 0 and 1 set, and bit 3 (fault-on-write) set when `tlb_fonw` is high.
- R9: A permitted store to an entry with `tlb_fonw` high gives fault code 3 with status bits 0 and 3 set.
- R10: A load whose read-enable bit is clear gives fault code 2. The status word has bit 1 set, and bit 2 (fault-on-read) set when `tlb_fonr` is high. A load never sets bits 0 or 3.
- R11: A permitted load to an entry with `tlb_fonr` high gives fault code 3 with only status bit 2 set.
- R12: Every other hit gives fault code 0, status 0, and physical address `{tlb_pfn, req_vaddr[12:0]}`. Any fault returns a physical address of zero.
- R13: The checks have a fixed priority: alignment first, then the window, then miss, then permission.
- R14: Each response adds one to exactly one of three counters, or to none. No-fault loads count in `cnt_rd_hit` and no-fault stores in `cnt_wr_hit`. Results with fault code 2 or 3 count in `cnt_viol`. Each counter wraps at its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_vld | input | 1 | Request present this cycle |
| req_vaddr | input | 48 | Virtual address |
| req_size | input | 2 | Access width code, 2^code bytes |
| req_wr | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | Privilege mode code |
| tlb_hit | input | 1 | Translation entry matched |
| tlb_pfn | input | 31 | Page frame number of the entry |
| tlb_rd_en | input | 4 | Per-mode read enable mask |
| tlb_wr_en | input | 4 | Per-mode write enable mask |
| tlb_fonr | input | 1 | Entry fault-on-read bit |
| tlb_fonw | input | 1 | Entry fault-on-write bit |
| rsp_vld | output | 1 | Result valid |
| rsp_pa | output | 44 | Physical address, zero on fault |
| rsp_fault | output | 3 | Fault code: 0 none, 1 alignment, 2 access violation, 3 page fault, 4 miss |
| rsp_stat | output | 4 | Status: bit0 write, bit1 access violation, bit2 fault-on-read, bit3 fault-on-write |
| cnt_rd_hit | output | 16 | No-fault load count |
| cnt_wr_hit | output | 16 | No-fault store count |
| cnt_viol | output | 16 | Violation count |

## Verification
The assertions check on every cycle that responses track requests one-for-one, and that loads never raise the write or fault-on-write bits. They also check that single-byte accesses never fault on alignment, that non-kernel window accesses and plain misses get their fault codes, and that the violation counter moves only on a violation response. The remaining behaviour is shown only by the bench scenarios: sign extension of window addresses, the status encodings for each permission and fault-on combination, mode-indexed mask selection, the overlaps between checks that reveal their priority, and the final counter totals.

// File: rtl/dxp_pkg.sv
package dxp_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_ACV   = 3'd2,
    FLT_PAGE  = 3'd3,
    FLT_MISS  = 3'd4
  } dxp_fault_e;

  localparam int ST_W    = 4;
  localparam int ST_WR   = 0;
  localparam int ST_ACV  = 1;
  localparam int ST_FONR = 2;
  localparam int ST_FONW = 3;

  localparam int MODE_W    = 2;
  localparam int NUM_MODES = 1 << MODE_W;
  localparam logic [MODE_W-1:0] MODE_KERNEL = '0;
endpackage

// File: rtl/dxp_align.sv
module dxp_align #(
  parameter int SZ_W = 2
) (
  input  logic [(2**SZ_W)-2:0] addr_lo,
  input  logic [SZ_W-1:0]      size,
  output logic                 misalign
);
  localparam int LOW_W = (2**SZ_W) - 1;

  logic [LOW_W-1:0] bad;

  for (genvar b = 0; b < LOW_W; b++) begin : g_bit
    assign bad[b] = addr_lo[b] && (int'(size) > b);
  end

  assign misalign = |bad;
endmodule

// File: rtl/dxp_spage.sv
module dxp_spage
  import dxp_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int PA_W     = 44,
  parameter int SPACE_LO = 41,
  parameter int SP_SPACE = 'h7e,
  parameter int SXT_BIT  = 40
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic [MODE_W-1:0] mode,
  output logic              in_window,
  output logic              deny,
  output logic [PA_W-1:0]   pa
);
  localparam int SPC_W = VA_W - SPACE_LO;
  localparam logic [SPC_W-1:0] SPACE_VAL = SPC_W'(SP_SPACE);
  localparam logic [PA_W-1:0]  SXT_MASK  = ~((PA_W'(1) << SXT_BIT) - PA_W'(1));

  logic [PA_W-1:0] pa_raw;

  assign in_window = (vaddr[VA_W-1:SPACE_LO] == SPACE_VAL);
  assign deny      = (mode != MODE_KERNEL);
  assign pa_raw    = vaddr[PA_W-1:0];
  assign pa        = pa_raw[SXT_BIT] ? (pa_raw | SXT_MASK) : pa_raw;
endmodule

// File: rtl/dxp_perm.sv
module dxp_perm
  import dxp_pkg::*;
(
  input  logic                 is_store,
  input  logic [MODE_W-1:0]    mode,
  input  logic [NUM_MODES-1:0] rd_en,
  input  logic [NUM_MODES-1:0] wr_en,
  input  logic                 fonr,
  input  logic                 fonw,
  output dxp_fault_e           fault,
  output logic [ST_W-1:0]      stat
);
  logic [NUM_MODES-1:0] sel;
  logic                 rd_ok;
  logic                 wr_ok;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    assign sel[m] = (mode == MODE_W'(m));
  end

  assign rd_ok = |(rd_en & sel);
  assign wr_ok = |(wr_en & sel);

  always_comb begin
    fault = FLT_NONE;
    stat  = '0;
    if (is_store) begin
      stat[ST_WR] = 1'b1;
      if (!wr_ok) begin
        fault         = FLT_PAGE;
        stat[ST_ACV]  = 1'b1;
        stat[ST_FONW] = fonw;
      end else if (fonw) begin
        fault         = FLT_PAGE;
        stat[ST_FONW] = 1'b1;
      end else begin
        stat = '0;
      end
    end else begin
      if (!rd_ok) begin
        fault         = FLT_ACV;
        stat[ST_ACV]  = 1'b1;
        stat[ST_FONR] = fonr;
      end else if (fonr) begin
        fault         = FLT_PAGE;
        stat[ST_FONR] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dxp_ctr.sv
module dxp_ctr #(
  parameter int N     = 3,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              inc,
  output logic [N-1:0][CNT_W-1:0]   cnt
);
  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
      cnt_nx = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
      end else if (inc[i]) begin
        cnt_q <= cnt_nx;
      end
    end

    assign cnt[i] = cnt_q;
  end
endmodule

// File: rtl/dxlate_perm_chk.sv
module dxlate_perm_chk
  import dxp_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int PA_W     = 44,
  parameter int PG_W     = 13,
  parameter int SZ_W     = 2,
  parameter int SPACE_LO = 41,
  parameter int SP_SPACE = 'h7e,
  parameter int SXT_BIT  = 40,
  parameter int CNT_W    = 16,
  localparam int PFN_W   = PA_W - PG_W,
  localparam int LOW_W   = (2**SZ_W) - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_vld,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic [SZ_W-1:0]      req_size,
  input  logic                 req_wr,
  input  logic [1:0]           req_mode,
  input  logic                 tlb_hit,
  input  logic [PFN_W-1:0]     tlb_pfn,
  input  logic [3:0]           tlb_rd_en,
  input  logic [3:0]           tlb_wr_en,
  input  logic                 tlb_fonr,
  input  logic                 tlb_fonw,
  output logic                 rsp_vld,
  output logic [PA_W-1:0]      rsp_pa,
  output logic [2:0]           rsp_fault,
  output logic [3:0]           rsp_stat,
  output logic [CNT_W-1:0]     cnt_rd_hit,
  output logic [CNT_W-1:0]     cnt_wr_hit,
  output logic [CNT_W-1:0]     cnt_viol
);
  localparam int CI_RD = 0;
  localparam int CI_WR = 1;
  localparam int CI_VL = 2;
  localparam int NCNT  = 3;

  logic             misalign;
  logic             sp_win;
  logic             sp_deny;
  logic [PA_W-1:0]  sp_pa;
  dxp_fault_e       perm_fault;
  logic [ST_W-1:0]  perm_stat;

  dxp_fault_e       fault_nx;
  logic [ST_W-1:0]  stat_nx;
  logic [PA_W-1:0]  pa_nx;

  logic             vld_q;
  dxp_fault_e       fault_q;
  logic [ST_W-1:0]  stat_q;
  logic [PA_W-1:0]  pa_q;

  logic [NCNT-1:0]              cnt_inc;
  logic [NCNT-1:0][CNT_W-1:0]   cnt_val;

  dxp_align #(.SZ_W(SZ_W)) u_align (
    .addr_lo  (req_vaddr[LOW_W-1:0]),
    .size     (req_size),
    .misalign (misalign)
  );

  dxp_spage #(
    .VA_W(VA_W), .PA_W(PA_W), .SPACE_LO(SPACE_LO),
    .SP_SPACE(SP_SPACE), .SXT_BIT(SXT_BIT)
  ) u_spage (
    .vaddr     (req_vaddr),
    .mode      (req_mode),
    .in_window (sp_win),
    .deny      (sp_deny),
    .pa        (sp_pa)
  );

  dxp_perm u_perm (
    .is_store (req_wr),
    .mode     (req_mode),
    .rd_en    (tlb_rd_en),
    .wr_en    (tlb_wr_en),
    .fonr     (tlb_fonr),
    .fonw     (tlb_fonw),
    .fault    (perm_fault),
    .stat     (perm_stat)
  );

  // Priority: alignment, window, miss, permission
  always_comb begin
    fault_nx = FLT_NONE;
    stat_nx  = '0;
    pa_nx    = '0;
    if (misalign) begin
      fault_nx       = FLT_ALIGN;
      stat_nx[ST_WR] = req_wr;
    end else if (sp_win) begin
      if (sp_deny) begin
        fault_nx        = FLT_ACV;
        stat_nx[ST_WR]  = req_wr;
        stat_nx[ST_ACV] = 1'b1;
      end else begin
        pa_nx = sp_pa;
      end
    end else if (!tlb_hit) begin
      fault_nx       = FLT_MISS;
      stat_nx[ST_WR] = req_wr;
    end else begin
      fault_nx = perm_fault;
      stat_nx  = perm_stat;
      if (perm_fault == FLT_NONE) begin
        pa_nx = {tlb_pfn, req_vaddr[PG_W-1:0]};
      end
    end
  end

  always_comb begin
    cnt_inc        = '0;
    cnt_inc[CI_RD] = req_vld && (fault_nx == FLT_NONE) && !req_wr;
    cnt_inc[CI_WR] = req_vld && (fault_nx == FLT_NONE) && req_wr;
    cnt_inc[CI_VL] = req_vld && ((fault_nx == FLT_ACV) || (fault_nx == FLT_PAGE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      fault_q <= FLT_NONE;
      stat_q  <= '0;
      pa_q    <= '0;
    end else begin
      vld_q <= req_vld;
      if (req_vld) begin
        fault_q <= fault_nx;
        stat_q  <= stat_nx;
        pa_q    <= pa_nx;
      end
    end
  end

  dxp_ctr #(.N(NCNT), .CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (cnt_inc),
    .cnt   (cnt_val)
  );

  assign rsp_vld    = vld_q;
  assign rsp_pa     = pa_q;
  assign rsp_fault  = fault_q;
  assign rsp_stat   = stat_q;
  assign cnt_rd_hit = cnt_val[CI_RD];
  assign cnt_wr_hit = cnt_val[CI_WR];
  assign cnt_viol   = cnt_val[CI_VL];
endmodule

// File: rtl/dxp_chk.sv
module dxp_chk #(
  parameter int VA_W     = 48,
  parameter int SPACE_LO = 41,
  parameter int SP_SPACE = 'h7e,
  parameter int SZ_W     = 2,
  parameter int CNT_W    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_vld,
  input logic [VA_W-1:0]  req_vaddr,
  input logic [SZ_W-1:0]  req_size,
  input logic             req_wr,
  input logic [1:0]       req_mode,
  input logic             tlb_hit,
  input logic             rsp_vld,
  input logic [2:0]       rsp_fault,
  input logic [3:0]       rsp_stat,
  input logic [CNT_W-1:0] cnt_viol
);
  localparam int SPC_W = VA_W - SPACE_LO;
  localparam logic [SPC_W-1:0] SPACE_VAL = SPC_W'(SP_SPACE);

  logic in_win;
  assign in_win = (req_vaddr[VA_W-1:SPACE_LO] == SPACE_VAL);

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);

  p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);

  p_byte_never_misaligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_size == '0) |=> (rsp_fault != 3'd1));

  p_window_user_acv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_size == '0 && in_win && req_mode != 2'd0)
      |=> (rsp_fault == 3'd2 && rsp_stat[1]));

  p_miss_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_size == '0 && !in_win && !tlb_hit) |=> (rsp_fault == 3'd4));

  p_load_no_write_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_wr) |=> (!rsp_stat[0] && !rsp_stat[3]));

  p_clean_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_fault == 3'd0) |-> (rsp_stat == 4'd0));

  p_viol_cnt_moves_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_viol != $past(cnt_viol)) |-> (rsp_vld && (rsp_fault == 3'd2 || rsp_fault == 3'd3)));
endmodule

bind dxlate_perm_chk dxp_chk #(
  .VA_W(VA_W), .SPACE_LO(SPACE_LO), .SP_SPACE(SP_SPACE), .SZ_W(SZ_W), .CNT_W(CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_vaddr (req_vaddr),
  .req_size  (req_size),
  .req_wr    (req_wr),
  .req_mode  (req_mode),
  .tlb_hit   (tlb_hit),
  .rsp_vld   (rsp_vld),
  .rsp_fault (rsp_fault),
  .rsp_stat  (rsp_stat),
  .cnt_viol  (cnt_viol)
);

// File: tb/dxlate_perm_chk_tb_top.sv
`timescale 1ns/100ps
module dxlate_perm_chk_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_vld;
  logic [47:0] req_vaddr;
  logic [1:0]  req_size;
  logic        req_wr;
  logic [1:0]  req_mode;
  logic        tlb_hit;
  logic [30:0] tlb_pfn;
  logic [3:0]  tlb_rd_en;
  logic [3:0]  tlb_wr_en;
  logic        tlb_fonr;
  logic        tlb_fonw;
  logic        rsp_vld;
  logic [43:0] rsp_pa;
  logic [2:0]  rsp_fault;
  logic [3:0]  rsp_stat;
  logic [15:0] cnt_rd_hit;
  logic [15:0] cnt_wr_hit;
  logic [15:0] cnt_viol;

  typedef struct packed {
    logic [43:0] pa;
    logic [2:0]  fault;
    logic [3:0]  stat;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  int    n_rd = 0, n_wr = 0, n_vl = 0;
  bit    finished = 0;

  dxlate_perm_chk dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_vaddr(req_vaddr),
    .req_size(req_size), .req_wr(req_wr), .req_mode(req_mode),
    .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn), .tlb_rd_en(tlb_rd_en),
    .tlb_wr_en(tlb_wr_en), .tlb_fonr(tlb_fonr), .tlb_fonw(tlb_fonw),
    .rsp_vld(rsp_vld), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_stat(rsp_stat), .cnt_rd_hit(cnt_rd_hit), .cnt_wr_hit(cnt_wr_hit),
    .cnt_viol(cnt_viol)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected result computed from the requirements
  function automatic exp_t model(input logic [47:0] va, input logic [1:0] sz,
      input logic wr, input logic [1:0] md, input logic hit, input logic [30:0] pfn,
      input logic [3:0] re, input logic [3:0] we, input logic fr, input logic fw);
    exp_t e;
    logic [43:0] p;
    e = '0;
    if ((int'(va[2:0]) & ((1 << sz) - 1)) != 0) begin
      e.fault = 3'd1; e.stat[0] = wr;
    end else if (va[47:41] == 7'h7e) begin
      if (md != 2'd0) begin
        e.fault = 3'd2; e.stat = {2'b00, 1'b1, wr};
      end else begin
        p = va[43:0];
        if (p[40]) p[43:40] = 4'hF;
        e.pa = p;
      end
    end else if (!hit) begin
      e.fault = 3'd4; e.stat[0] = wr;
    end else if (wr) begin
      if (!we[md])   begin e.fault = 3'd3; e.stat = {fw, 1'b0, 1'b1, 1'b1}; end
      else if (fw)   begin e.fault = 3'd3; e.stat = 4'b1001; end
      else           e.pa = {pfn, va[12:0]};
    end else begin
      if (!re[md])   begin e.fault = 3'd2; e.stat = {1'b0, fr, 1'b1, 1'b0}; end
      else if (fr)   begin e.fault = 3'd3; e.stat = 4'b0100; end
      else           e.pa = {pfn, va[12:0]};
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, expv);
    end
  endtask

  task automatic send(input logic [47:0] va, input logic [1:0] sz, input logic wr,
      input logic [1:0] md, input logic hit, input logic [30:0] pfn,
      input logic [3:0] re, input logic [3:0] we, input logic fr, input logic fw,
      input string rq);
    exp_t e;
    @(negedge clk);
    req_vld = 1'b1; req_vaddr = va; req_size = sz; req_wr = wr; req_mode = md;
    tlb_hit = hit; tlb_pfn = pfn; tlb_rd_en = re; tlb_wr_en = we;
    tlb_fonr = fr; tlb_fonw = fw;
    e = model(va, sz, wr, md, hit, pfn, re, we, fr, fw);
    if (e.fault == 3'd0 && !wr) n_rd++;
    if (e.fault == 3'd0 && wr)  n_wr++;
    if (e.fault == 3'd2 || e.fault == 3'd3) n_vl++;
    exp_q.push_back(e);
    tag_q.push_back(rq);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_vld = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected response", 64'(rsp_vld), 64'd0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_fault == e.fault, t, "fault", 64'(rsp_fault), 64'(e.fault));
        check(rsp_stat == e.stat, t, "status", 64'(rsp_stat), 64'(e.stat));
        check(rsp_pa == e.pa, t, "paddr", 64'(rsp_pa), 64'(e.pa));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  localparam logic [47:0] WIN = {7'h7e, 41'd0};

  initial begin
    rst_n = 1'b0; req_vld = 1'b0; req_vaddr = '0; req_size = '0; req_wr = 1'b0;
    req_mode = '0; tlb_hit = 1'b0; tlb_pfn = '0; tlb_rd_en = '0; tlb_wr_en = '0;
    tlb_fonr = 1'b0; tlb_fonw = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rsp_vld == 1'b0, "R1", "rsp_vld in reset", 64'(rsp_vld), 64'd0);
    check(cnt_rd_hit == 0 && cnt_wr_hit == 0 && cnt_viol == 0, "R1", "counters in reset",
          64'({cnt_rd_hit, cnt_wr_hit, cnt_viol}), 64'd0);
    @(posedge clk); rst_n = 1'b1;
    idle(2);

    // R12: plain translations, loads and stores, several modes
    send(48'h0000_1234_5678, 2'd3, 1'b0, 2'd3, 1'b1, 31'h1234_567, 4'hF, 4'hF, 1'b0, 1'b0, "R12");
    send(48'h0012_3456_7ffc, 2'd2, 1'b1, 2'd0, 1'b1, 31'h7fff_ffff, 4'hF, 4'hF, 1'b0, 1'b0, "R12");
    send(48'h7fff_0000_1fff, 2'd0, 1'b0, 2'd1, 1'b1, 31'h0, 4'h2, 4'h0, 1'b0, 1'b0, "R12");
    // R2: alignment
    send(48'h0000_0000_1004, 2'd3, 1'b1, 2'd0, 1'b1, 31'h5, 4'hF, 4'hF, 1'b0, 1'b0, "R2");
    send(48'h0000_0000_1001, 2'd1, 1'b0, 2'd0, 1'b1, 31'h5, 4'hF, 4'hF, 1'b0, 1'b0, "R2");
    send(48'h0000_0000_1002, 2'd2, 1'b0, 2'd0, 1'b1, 31'h5, 4'hF, 4'hF, 1'b0, 1'b0, "R2");
    send(48'h0000_0000_1002, 2'd1, 1'b0, 2'd0, 1'b1, 31'h5, 4'hF, 4'hF, 1'b0, 1'b0, "R2");
    idle(1);
    // R3/R4: kernel window, ignoring the entry
    send(WIN | 48'h0000_1234_5678, 2'd3, 1'b0, 2'd0, 1'b0, 31'h0, 4'h0, 4'h0, 1'b1, 1'b1, "R3");
    send(WIN | 48'h0100_0000_0040, 2'd2, 1'b1, 2'd0, 1'b1, 31'h1, 4'h0, 4'h0, 1'b1, 1'b1, "R4");
    send(WIN | 48'h01ff_ffff_fff8, 2'd3, 1'b0, 2'd0, 1'b1, 31'h1, 4'h0, 4'h0, 1'b0, 1'b0, "R4");
    // R5: window outside kernel
    send(WIN | 48'h0000_0000_0010, 2'd3, 1'b1, 2'd3, 1'b1, 31'h9, 4'hF, 4'hF, 1'b0, 1'b0, "R5");
    send(WIN | 48'h0000_0000_0010, 2'd0, 1'b0, 2'd1, 1'b1, 31'h9, 4'hF, 4'hF, 1'b0, 1'b0, "R5");
    // R6: miss
    send(48'h0000_0000_4000, 2'd2, 1'b0, 2'd0, 1'b0, 31'h9, 4'hF, 4'hF, 1'b0, 1'b0, "R6");
    send(48'h0000_0000_4000, 2'd2, 1'b1, 2'd2, 1'b0, 31'h9, 4'hF, 4'hF, 1'b0, 1'b0, "R6");
    idle(2);
    // R8/R9: stores
    send(48'h0000_0000_8000, 2'd3, 1'b1, 2'd3, 1'b1, 31'h3, 4'hF, 4'h7, 1'b0, 1'b1, "R8");
    send(48'h0000_0000_8000, 2'd3, 1'b1, 2'd3, 1'b1, 31'h3, 4'hF, 4'h7, 1'b0, 1'b0, "R8");
    send(48'h0000_0000_8000, 2'd3, 1'b1, 2'd3, 1'b1, 31'h3, 4'hF, 4'hF, 1'b1, 1'b1, "R9");
    // R10/R11: loads
    send(48'h0000_0000_9000, 2'd1, 1'b0, 2'd2, 1'b1, 31'h4, 4'hB, 4'hF, 1'b1, 1'b1, "R10");
    send(48'h0000_0000_9000, 2'd1, 1'b0, 2'd2, 1'b1, 31'h4, 4'hB, 4'hF, 1'b0, 1'b1, "R10");
    send(48'h0000_0000_9000, 2'd1, 1'b0, 2'd2, 1'b1, 31'h4, 4'hF, 4'h0, 1'b1, 1'b0, "R11");
    // R7: mode-indexed mask selection
    send(48'h0000_0000_a000, 2'd0, 1'b0, 2'd2, 1'b1, 31'h6, 4'h4, 4'h0, 1'b0, 1'b0, "R7");
    send(48'h0000_0000_a000, 2'd0, 1'b0, 2'd1, 1'b1, 31'h6, 4'h4, 4'h0, 1'b0, 1'b0, "R7");
    send(48'h0000_0000_a000, 2'd0, 1'b1, 2'd1, 1'b1, 31'h6, 4'h0, 4'h2, 1'b0, 1'b0, "R7");
    send(48'h0000_0000_a000, 2'd0, 1'b1, 2'd0, 1'b1, 31'h6, 4'h0, 4'h2, 1'b0, 1'b0, "R7");
    // R13: priority overlaps
    send(WIN | 48'h0000_0000_0003, 2'd2, 1'b1, 2'd3, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0, "R13");
    send(WIN | 48'h0000_0000_0008, 2'd3, 1'b1, 2'd3, 1'b0, 31'h0, 4'h0, 4'h0, 1'b0, 1'b0, "R13");
    send(48'h0000_0000_c000, 2'd3, 1'b1, 2'd3, 1'b0, 31'h0, 4'h0, 4'h0, 1'b1, 1'b1, "R13");
    send(48'h0000_0000_c001, 2'd1, 1'b0, 2'd3, 1'b1, 31'h0, 4'h0, 4'h0, 1'b1, 1'b1, "R13");
    idle(3);

    // R14: counter totals; R1: every request answered
    check(exp_q.size() == 0, "R1", "pending responses", 64'(exp_q.size()), 64'd0);
    check(cnt_rd_hit == 16'(n_rd), "R14", "read hit count", 64'(cnt_rd_hit), 64'(n_rd));
    check(cnt_wr_hit == 16'(n_wr), "R14", "write hit count", 64'(cnt_wr_hit), 64'(n_wr));
    check(cnt_viol == 16'(n_vl), "R14", "violation count", 64'(cnt_viol), 64'(n_vl));
    finish_run();
  end
endmodule